// File: doc/BRIEF.md
# Move and Byte-Reverse Execution Unit

This block is one execution slice of a 32-bit processor datapath. It takes an already decoded operation and produces a destination result and updated condition flags one clock later. It covers five kinds of work: copying the second operand, copying its bitwise complement, inserting a 16-bit immediate into the upper half of the destination, and rearranging the bytes or bits of the operand.

Upstream logic supplies the second operand and the shifter's carry-out. It also supplies the current destination value, the current flags and a condition-pass qualifier. The block decides whether the result and the flags are written. It also flags an upper-half insert that targets a forbidden register (stack pointer or program counter). Decode, the shifter, the register file and condition evaluation sit outside it.

Top module: `mvrev_unit`

## Requirements
- R1: Opcode 0 (copy) outputs `operandB` as the result. Opcode 1 (invert) outputs its bitwise complement, so 0x0000000F gives 0xFFFFFFF0.
- R2: When `setFlags` is high and the opcode is 0 or 1, `flagsWe` is high. In `flagsOut`, laid out as {N,Z,C,V} in bits 3..0, N is result bit 31 and Z is 1 exactly when the result is zero.
- R3: On a flag-writing copy or invert, C takes `shiftCarry` when `shiftCarryValid` is high. Otherwise C keeps the incoming C from `flagsIn[1]`.
- R4: V in `flagsOut[0]` always equals the incoming `flagsIn[0]` of the issued operation.
- R5: Opcode 2 (upper insert) outputs {`imm16`, `rdValue[15:0]`}. It never asserts `flagsWe`.
- R6: Opcode 2 with `rdIndex` 13 or 15 raises `illegalDest` for that result cycle and holds `resultWe` low.
- R7: Opcode 3 maps bytes [B3,B2,B1,B0] to [B0,B1,B2,B3]. Opcode 4 maps them to [B2,B3,B0,B1].
- R8: Opcode 5 swaps the two low bytes and sign-extends the swapped halfword to 32 bits. Opcode 6 moves bit i to bit 31-i. Opcodes 2 to 6 never assert `flagsWe`, even when `setFlags` is high.
- R9: With `condPass` low, `resultWe` and `flagsWe` stay low, and `flagsOut` equals the incoming flags.
- R10: With `setFlags` low, `flagsWe` stays low and `flagsOut` equals the incoming flags.
- R11: Results appear one cycle after issue, with `outValid` high. A cycle without `inIssue` gives `outValid`, `resultWe`, `flagsWe` and `illegalDest` low. After reset, all outputs are zero.
- R12: Opcode 7 is reserved. It writes neither the result nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inIssue | input | 1 | An operation is presented this cycle |
| opSel | input | 3 | Operation code (0..7, see requirements) |
| setFlags | input | 1 | Request flag update |
| condPass | input | 1 | Condition check passed |
| operandB | input | 32 | Second operand |
| shiftCarryValid | input | 1 | Shifter produced a carry-out |
| shiftCarry | input | 1 | Shifter carry-out |
| imm16 | input | 16 | Immediate for the upper insert |
| rdValue | input | 32 | Current destination register value |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| rdIndex | input | 4 | Destination register index |
| outValid | output | 1 | Result cycle strobe |
| result | output | 32 | Result word |
| resultWe | output | 1 | Result write-enable |
| flagsOut | output | 4 | Updated flags {N,Z,C,V} |
| flagsWe | output | 1 | Flag write-enable |
| illegalDest | output | 1 | Forbidden destination on upper insert |

## Verification
The properties assume that `rdValue`, `imm16`, `flagsIn` and the control inputs are settled for the whole cycle in which `inIssue` is high. They also assume these inputs are never X during or after reset. The bench drives every input to a known value at time zero. It changes the inputs only on the falling edge, one operation per cycle, and it keeps the opcode within the 3-bit range with opcode 7 used on purpose.

// File: rtl/mvrev_pkg.sv
package mvrev_pkg;

  typedef enum logic [2:0] {
    OP_COPY   = 3'd0,
    OP_INVERT = 3'd1,
    OP_UPPER  = 3'd2,
    OP_REVW   = 3'd3,
    OP_REVH   = 3'd4,
    OP_REVSH  = 3'd5,
    OP_BITREV = 3'd6,
    OP_RSVD   = 3'd7
  } mvOp_e;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;

  typedef struct packed {
    logic issue;
    logic wrRes;
    logic wrFlags;
    logic badDest;
  } mvStrobe_t;

endpackage

// File: rtl/mvrev_ctrl.sv
module mvrev_ctrl
  import mvrev_pkg::*;
#(
  parameter int unsigned REG_IDX_W = 4,
  parameter int unsigned SP_IDX    = 13,
  parameter int unsigned PC_IDX    = 15
) (
  input  logic                 inIssue,
  input  logic [2:0]           opSel,
  input  logic                 setFlags,
  input  logic                 condPass,
  input  logic [REG_IDX_W-1:0] rdIndex,
  output mvStrobe_t            strobe
);

  localparam logic [REG_IDX_W-1:0] SpIdx = REG_IDX_W'(SP_IDX);
  localparam logic [REG_IDX_W-1:0] PcIdx = REG_IDX_W'(PC_IDX);

  mvOp_e op;
  logic  isMove;
  logic  isUpper;
  logic  isKnown;
  logic  restricted;

  always_comb begin
    op         = mvOp_e'(opSel);
    isMove     = (op == OP_COPY) || (op == OP_INVERT);
    isUpper    = (op == OP_UPPER);
    isKnown    = (op != OP_RSVD);
    restricted = (rdIndex == SpIdx) || (rdIndex == PcIdx);

    strobe.issue   = inIssue;
    strobe.badDest = inIssue && isUpper && restricted;
    strobe.wrRes   = inIssue && condPass && isKnown && !(isUpper && restricted);
    strobe.wrFlags = inIssue && condPass && setFlags && isMove;
  end

endmodule

// File: rtl/mvrev_dp.sv
module mvrev_dp
  import mvrev_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            opSel,
  input  mvStrobe_t             strobe,
  input  logic [DATA_W-1:0]     operandB,
  input  logic                  shiftCarryValid,
  input  logic                  shiftCarry,
  input  logic [DATA_W/2-1:0]   imm16,
  input  logic [DATA_W-1:0]     rdValue,
  input  logic [3:0]            flagsIn,
  output logic                  outValid,
  output logic [DATA_W-1:0]     result,
  output logic                  resultWe,
  output logic [3:0]            flagsOut,
  output logic                  flagsWe,
  output logic                  illegalDest
);

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned NBYTES = DATA_W / BYTE_W;

  logic [DATA_W-1:0] revWord;
  logic [DATA_W-1:0] revHalf;
  logic [DATA_W-1:0] revSigned;
  logic [DATA_W-1:0] bitRev;
  logic [HALF_W-1:0] lowSwap;
  logic [DATA_W-1:0] nextRes;
  logic [3:0]        nextFlags;

  for (genvar b = 0; b < NBYTES; b++) begin : g_bytes
    assign revWord[b*BYTE_W +: BYTE_W] = operandB[(NBYTES-1-b)*BYTE_W +: BYTE_W];
    assign revHalf[b*BYTE_W +: BYTE_W] = operandB[(b ^ 1)*BYTE_W +: BYTE_W];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bits
    assign bitRev[i] = operandB[DATA_W-1-i];
  end

  assign lowSwap   = revHalf[HALF_W-1:0];
  assign revSigned = {{HALF_W{lowSwap[HALF_W-1]}}, lowSwap};

  always_comb begin
    unique case (mvOp_e'(opSel))
      OP_COPY:   nextRes = operandB;
      OP_INVERT: nextRes = ~operandB;
      OP_UPPER:  nextRes = {imm16, rdValue[HALF_W-1:0]};
      OP_REVW:   nextRes = revWord;
      OP_REVH:   nextRes = revHalf;
      OP_REVSH:  nextRes = revSigned;
      OP_BITREV: nextRes = bitRev;
      default:   nextRes = rdValue;
    endcase
  end

  always_comb begin
    nextFlags = flagsIn;
    if (strobe.wrFlags) begin
      nextFlags[FLAG_N] = nextRes[DATA_W-1];
      nextFlags[FLAG_Z] = (nextRes == '0);
      nextFlags[FLAG_C] = shiftCarryValid ? shiftCarry : flagsIn[FLAG_C];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      result      <= '0;
      resultWe    <= 1'b0;
      flagsOut    <= '0;
      flagsWe     <= 1'b0;
      illegalDest <= 1'b0;
    end else begin
      outValid    <= strobe.issue;
      resultWe    <= strobe.wrRes;
      flagsWe     <= strobe.wrFlags;
      illegalDest <= strobe.badDest;
      if (strobe.issue) begin
        result   <= nextRes;
        flagsOut <= nextFlags;
      end
    end
  end

endmodule

// File: rtl/mvrev_unit.sv
module mvrev_unit
  import mvrev_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_IDX_W = 4,
  parameter int unsigned SP_IDX    = 13,
  parameter int unsigned PC_IDX    = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inIssue,
  input  logic [2:0]           opSel,
  input  logic                 setFlags,
  input  logic                 condPass,
  input  logic [DATA_W-1:0]    operandB,
  input  logic                 shiftCarryValid,
  input  logic                 shiftCarry,
  input  logic [DATA_W/2-1:0]  imm16,
  input  logic [DATA_W-1:0]    rdValue,
  input  logic [3:0]           flagsIn,
  input  logic [REG_IDX_W-1:0] rdIndex,
  output logic                 outValid,
  output logic [DATA_W-1:0]    result,
  output logic                 resultWe,
  output logic [3:0]           flagsOut,
  output logic                 flagsWe,
  output logic                 illegalDest
);

  mvStrobe_t strobe;

  mvrev_ctrl #(
    .REG_IDX_W(REG_IDX_W),
    .SP_IDX   (SP_IDX),
    .PC_IDX   (PC_IDX)
  ) u_ctrl (
    .inIssue (inIssue),
    .opSel   (opSel),
    .setFlags(setFlags),
    .condPass(condPass),
    .rdIndex (rdIndex),
    .strobe  (strobe)
  );

  mvrev_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .opSel          (opSel),
    .strobe         (strobe),
    .operandB       (operandB),
    .shiftCarryValid(shiftCarryValid),
    .shiftCarry     (shiftCarry),
    .imm16          (imm16),
    .rdValue        (rdValue),
    .flagsIn        (flagsIn),
    .outValid       (outValid),
    .result         (result),
    .resultWe       (resultWe),
    .flagsOut       (flagsOut),
    .flagsWe        (flagsWe),
    .illegalDest    (illegalDest)
  );

endmodule

// File: rtl/mvrev_checker.sv
module mvrev_checker #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_IDX_W = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inIssue,
  input logic [2:0]           opSel,
  input logic                 setFlags,
  input logic                 condPass,
  input logic [DATA_W/2-1:0]  imm16,
  input logic [DATA_W-1:0]    rdValue,
  input logic [3:0]           flagsIn,
  input logic [REG_IDX_W-1:0] rdIndex,
  input logic                 outValid,
  input logic [DATA_W-1:0]    result,
  input logic                 resultWe,
  input logic [3:0]           flagsOut,
  input logic                 flagsWe,
  input logic                 illegalDest
);

  localparam int unsigned HALF_W = DATA_W / 2;

  AST_FLAG_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    flagsWe |-> (flagsOut[2] == (result == '0)) && (flagsOut[3] == result[DATA_W-1])); // R2

  AST_V_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    inIssue |=> flagsOut[0] == $past(flagsIn[0])); // R4

  AST_UPPER_HALVES: assert property (@(posedge clk) disable iff (!rstN)
    (inIssue && opSel == 3'd2 && condPass && rdIndex != 4'd13 && rdIndex != 4'd15)
    |=> resultWe && !flagsWe && result == {$past(imm16), $past(rdValue[HALF_W-1:0])}); // R5

  AST_BAD_DEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    illegalDest |-> !resultWe); // R6

  AST_FLAGS_MOVE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (inIssue && opSel != 3'd0 && opSel != 3'd1) |=> !flagsWe); // R8

  AST_COND_FAIL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (inIssue && !condPass) |=> !resultWe && !flagsWe); // R9

  AST_NO_FLAG_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    (inIssue && !setFlags) |=> !flagsWe && flagsOut == $past(flagsIn)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inIssue |=> !outValid && !resultWe && !flagsWe && !illegalDest); // R11

  AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (inIssue && opSel == 3'd7) |=> outValid && !resultWe && !flagsWe); // R12

endmodule

bind mvrev_unit mvrev_checker #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) u_chk (.*);

// File: tb/mvrev_unit_bench.sv
module mvrev_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inIssue = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic        setFlags = 1'b0;
  logic        condPass = 1'b0;
  logic [31:0] operandB = '0;
  logic        shiftCarryValid = 1'b0;
  logic        shiftCarry = 1'b0;
  logic [15:0] imm16 = '0;
  logic [31:0] rdValue = '0;
  logic [3:0]  flagsIn = '0;
  logic [3:0]  rdIndex = '0;
  logic        outValid;
  logic [31:0] result;
  logic        resultWe;
  logic [3:0]  flagsOut;
  logic        flagsWe;
  logic        illegalDest;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mvrev_unit u_mvrev_unit (
    .clk(clk), .rstN(rstN), .inIssue(inIssue), .opSel(opSel),
    .setFlags(setFlags), .condPass(condPass), .operandB(operandB),
    .shiftCarryValid(shiftCarryValid), .shiftCarry(shiftCarry),
    .imm16(imm16), .rdValue(rdValue), .flagsIn(flagsIn), .rdIndex(rdIndex),
    .outValid(outValid), .result(result), .resultWe(resultWe),
    .flagsOut(flagsOut), .flagsWe(flagsWe), .illegalDest(illegalDest)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic issueOp(logic [2:0] op, logic sf, logic cp, logic [31:0] b,
                         logic cv, logic c, logic [15:0] imm, logic [31:0] rdv,
                         logic [3:0] fl, logic [3:0] idx);
    @(negedge clk);
    inIssue = 1'b1; opSel = op; setFlags = sf; condPass = cp; operandB = b;
    shiftCarryValid = cv; shiftCarry = c; imm16 = imm; rdValue = rdv;
    flagsIn = fl; rdIndex = idx;
    @(negedge clk);
  endtask

  task automatic expectOut(string req, bit chkRes, logic [31:0] expRes, logic expWe,
                           logic [3:0] expFl, logic expFwe, logic expIll);
    chk("R11", {req, " outValid"}, {31'd0, outValid}, 32'd1);
    if (chkRes) chk(req, "result", result, expRes);
    chk(req, "resultWe", {31'd0, resultWe}, {31'd0, expWe});
    chk(req, "flagsOut", {28'd0, flagsOut}, {28'd0, expFl});
    chk(req, "flagsWe", {31'd0, flagsWe}, {31'd0, expFwe});
    chk(req, "illegalDest", {31'd0, illegalDest}, {31'd0, expIll});
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R11", "reset outValid", {31'd0, outValid}, 32'd0);
    chk("R11", "reset result", result, 32'd0);
    chk("R11", "reset flags", {28'd0, flagsOut}, 32'd0);
    chk("R11", "reset we", {30'd0, resultWe, flagsWe}, 32'd0);
  endtask

  task automatic testCopy();
    issueOp(3'd0, 1'b0, 1'b1, 32'h0000FA05, 1'b1, 1'b1, 16'h0, 32'h0, 4'b0101, 4'd1);
    expectOut("R1/R10 copy no flags", 1, 32'h0000FA05, 1'b1, 4'b0101, 1'b0, 1'b0);
    issueOp(3'd0, 1'b1, 1'b1, 32'h8000000B, 1'b1, 1'b1, 16'h0, 32'h0, 4'b0001, 4'd2);
    expectOut("R2/R3/R4 copy negative", 1, 32'h8000000B, 1'b1, 4'b1011, 1'b1, 1'b0);
    issueOp(3'd0, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0, 16'h0, 32'h0, 4'b0010, 4'd2);
    expectOut("R2/R3 copy zero C kept", 1, 32'h0, 1'b1, 4'b0110, 1'b1, 1'b0);
  endtask

  task automatic testInvert();
    issueOp(3'd1, 1'b1, 1'b1, 32'h0000000F, 1'b1, 1'b0, 16'h0, 32'h0, 4'b1111, 4'd2);
    expectOut("R1/R3/R4 invert 0xF", 1, 32'hFFFFFFF0, 1'b1, 4'b1001, 1'b1, 1'b0);
    issueOp(3'd1, 1'b1, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b1, 16'h0, 32'h0, 4'b0000, 4'd2);
    expectOut("R2/R3 invert to zero", 1, 32'h0, 1'b1, 4'b0100, 1'b1, 1'b0);
  endtask

  task automatic testUpper();
    issueOp(3'd2, 1'b1, 1'b1, 32'h0, 1'b1, 1'b1, 16'hF123, 32'h1234ABCD, 4'b0110, 4'd3);
    expectOut("R5 upper insert", 1, 32'hF123ABCD, 1'b1, 4'b0110, 1'b0, 1'b0);
    issueOp(3'd2, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 16'h5555, 32'h0, 4'b0011, 4'd13);
    expectOut("R6 upper to SP", 0, 32'h0, 1'b0, 4'b0011, 1'b0, 1'b1);
    issueOp(3'd2, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 16'h5555, 32'h0, 4'b0011, 4'd15);
    expectOut("R6 upper to PC", 0, 32'h0, 1'b0, 4'b0011, 1'b0, 1'b1);
  endtask

  task automatic testReverse();
    issueOp(3'd3, 1'b1, 1'b1, 32'h11223344, 1'b1, 1'b1, 16'h0, 32'h0, 4'b0000, 4'd4);
    expectOut("R7/R8 word reverse", 1, 32'h44332211, 1'b1, 4'b0000, 1'b0, 1'b0);
    issueOp(3'd4, 1'b0, 1'b1, 32'h11223344, 1'b0, 1'b0, 16'h0, 32'h0, 4'b1000, 4'd4);
    expectOut("R7 half reverse", 1, 32'h22114433, 1'b1, 4'b1000, 1'b0, 1'b0);
    issueOp(3'd5, 1'b1, 1'b1, 32'h000080FF, 1'b1, 1'b0, 16'h0, 32'h0, 4'b0100, 4'd4);
    expectOut("R8 signed reverse neg", 1, 32'hFFFFFF80, 1'b1, 4'b0100, 1'b0, 1'b0);
    issueOp(3'd5, 1'b0, 1'b1, 32'h12340011, 1'b0, 1'b0, 16'h0, 32'h0, 4'b0100, 4'd4);
    expectOut("R8 signed reverse pos", 1, 32'h00001100, 1'b1, 4'b0100, 1'b0, 1'b0);
    issueOp(3'd6, 1'b1, 1'b1, 32'h0000000F, 1'b1, 1'b1, 16'h0, 32'h0, 4'b0001, 4'd4);
    expectOut("R8 bit mirror", 1, 32'hF0000000, 1'b1, 4'b0001, 1'b0, 1'b0);
  endtask

  task automatic testCondFail();
    issueOp(3'd0, 1'b1, 1'b0, 32'h00000000, 1'b1, 1'b1, 16'h0, 32'h0, 4'b1010, 4'd5);
    expectOut("R9 condition fail", 0, 32'h0, 1'b0, 4'b1010, 1'b0, 1'b0);
  endtask

  task automatic testReserved();
    issueOp(3'd7, 1'b1, 1'b1, 32'hDEADBEEF, 1'b1, 1'b1, 16'h0, 32'h0, 4'b0110, 4'd6);
    expectOut("R12 reserved op", 0, 32'h0, 1'b0, 4'b0110, 1'b0, 1'b0);
  endtask

  task automatic testIdle();
    issueOp(3'd2, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 16'h1, 32'h0, 4'b0000, 4'd13);
    inIssue = 1'b0;
    @(negedge clk);
    chk("R11", "idle outValid", {31'd0, outValid}, 32'd0);
    chk("R11", "idle strobes", {29'd0, resultWe, flagsWe, illegalDest}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testCopy();
    testInvert();
    testUpper();
    testReverse();
    testCondFail();
    testReserved();
    testIdle();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule